// File: doc/BRIEF.md
# Debug Hardware Command Executor

This block sits between a debug link front end and the system bus. It takes one command at a time: an 8-bit opcode with a 16-bit address and, for writes, 16-bit data, all presented in parallel. It turns each into a single bus access or into a change of its own state. Reads come back as a 16-bit word with a one-cycle valid strobe. Byte data rides on the lane that matches the parity of the address. A per-access select line tells the bus to let the debug register window override application memory at the same address. That select is raised only for the mapped-in commands and only while that access is pending.

Two further functions are built in. The first is a request to enter background mode, which is honoured only while the firmware-enable input is high. The second is an optional acknowledge handshake: a one-clock ACK pulse that marks the end of each command while the handshake is switched on. Bus arbitration, the serial bit protocol and the firmware are outside the block. The bus side is a plain request/grant pair, and the bus may hold off the grant for any number of cycles.

Top module: `dbg_cmd_exec`

## Requirements
- R1: Opcode 0xEC reads a word and 0xE4 reads a byte with `bus_dbg_sel` high. Opcode 0xE8 reads a word and 0xE0 reads a byte with `bus_dbg_sel` low. Each read makes exactly one bus access with `bus_we` low.
- R2: A byte read at an odd address returns the memory's bits 7:0 in `rsp_data[7:0]` with bits 15:8 zero. A byte read at an even address returns bits 15:8 in `rsp_data[15:8]` with bits 7:0 zero. A word read returns all 16 bits.
- R3: Opcode 0xC4 writes one byte with `bus_dbg_sel` high and `bus_we` high. `bus_be` is 2'b01 for an odd address and 2'b10 for an even address. `cmd_wdata` is passed unchanged to `bus_wdata`.
- R4: A word command (0xEC or 0xE8) with address bit 0 set makes no bus access and raises `align_err` for one clock. It produces no ACK and no `rsp_valid`.
- R5: While the handshake flag is set, `ack` pulses for exactly one clock after each completed command. While the flag is clear, `ack` stays low. Reset clears the flag.
- R6: Opcode 0xD5 sets the handshake flag and produces an ACK. Opcode 0xD6 clears the flag and produces no ACK. Neither makes a bus access.
- R7: Opcode 0x90 with `fw_enable` high raises `bg_req` and holds it until `bg_entered` is sampled high. Only then is an ACK issued, if the handshake is on. With `fw_enable` low, the command does nothing.
- R8: Any other opcode is ignored: no bus access, no ACK, no error and no response.
- R9: `bus_req` stays high with a stable address until `bus_gnt` is sampled high. Read data appears with `rsp_valid` on the clock after the grant. Commands offered while `busy` is high are not accepted.
- R10: After reset, `bus_req`, `rsp_valid`, `ack`, `align_err`, `bg_req` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 16 | Target byte address |
| cmd_wdata | input | 16 | Write data, byte on its address lane |
| fw_enable | input | 1 | Firmware enabled; gates background entry |
| bg_entered | input | 1 | Background mode has become active |
| busy | output | 1 | A command is in progress |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_dbg_sel | output | 1 | Debug register window overrides memory for this access |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_be | output | 2 | Byte lanes written; bit 1 is the high byte |
| bus_gnt | input | 1 | Access completes this cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_gnt` |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | 16 | Read result |
| ack | output | 1 | Handshake pulse |
| align_err | output | 1 | Unaligned word command rejected |
| bg_req | output | 1 | Request to enter background mode |

## Verification
The bus model keeps application memory and a small debug register window that share addresses. Reads of the same address with the mapped and unmapped opcodes must therefore return different words. Byte reads and writes at odd and at even addresses separate the two lanes, and a write followed by a word read shows that only the chosen lane changed. The same read is run with the handshake on and off, after a reset, and with grant delays, which separates ACK timing from data timing. An unaligned word address, an unknown opcode, a command offered while busy, and background entry with and without firmware enable each test one path that must stay silent or wait.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam logic [7:0] OP_BG       = 8'h90;
  localparam logic [7:0] OP_HS_ON    = 8'hD5;
  localparam logic [7:0] OP_HS_OFF   = 8'hD6;
  localparam logic [7:0] OP_RDB_MAP  = 8'hE4;
  localparam logic [7:0] OP_RDW_MAP  = 8'hEC;
  localparam logic [7:0] OP_RDB_APP  = 8'hE0;
  localparam logic [7:0] OP_RDW_APP  = 8'hE8;
  localparam logic [7:0] OP_WRB_MAP  = 8'hC4;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_WRITE,
    K_BGND,
    K_HS_ON,
    K_HS_OFF
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e kind;
    logic      is_byte;
    logic      dbg_map;
  } cmd_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUS,
    ST_BG
  } exec_st_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output cmd_dec_t        dec
);

  always_comb begin
    dec = '{kind: K_NONE, is_byte: 1'b0, dbg_map: 1'b0};
    case (op)
      OP_RDB_MAP: dec = '{kind: K_READ,   is_byte: 1'b1, dbg_map: 1'b1};
      OP_RDW_MAP: dec = '{kind: K_READ,   is_byte: 1'b0, dbg_map: 1'b1};
      OP_RDB_APP: dec = '{kind: K_READ,   is_byte: 1'b1, dbg_map: 1'b0};
      OP_RDW_APP: dec = '{kind: K_READ,   is_byte: 1'b0, dbg_map: 1'b0};
      OP_WRB_MAP: dec = '{kind: K_WRITE,  is_byte: 1'b1, dbg_map: 1'b1};
      OP_BG:      dec = '{kind: K_BGND,   is_byte: 1'b0, dbg_map: 1'b0};
      OP_HS_ON:   dec = '{kind: K_HS_ON,  is_byte: 1'b0, dbg_map: 1'b0};
      OP_HS_OFF:  dec = '{kind: K_HS_OFF, is_byte: 1'b0, dbg_map: 1'b0};
      default:    dec = '{kind: K_NONE,   is_byte: 1'b0, dbg_map: 1'b0};
    endcase
  end

endmodule

// File: rtl/dbg_be_gen.sv
module dbg_be_gen #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LO_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LO_W-1:0]  addr_lo,
  input  logic             is_byte,
  output logic [LANES-1:0] be,
  output logic             misaligned
);

  // Lowest address byte rides on the most significant lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int OFFS = LANES - 1 - l;
    assign be[l] = !is_byte || (addr_lo == LO_W'(OFFS));
  end

  assign misaligned = !is_byte && (addr_lo != '0);

endmodule

// File: rtl/dbg_rd_steer.sv
module dbg_rd_steer #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LO_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LO_W-1:0]   addr_lo,
  input  logic              is_byte,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int OFFS = LANES - 1 - l;
    logic keep;
    assign keep = !is_byte || (addr_lo == LO_W'(OFFS));
    assign dout[l*8 +: 8] = keep ? din[l*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/dbg_hs_flag.sv
module dbg_hs_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr_en,
  output logic hs_en
);

  always_ff @(posedge clk) begin
    if (rst)         hs_en <= 1'b0;
    else if (clr_en) hs_en <= 1'b0;
    else if (set_en) hs_en <= 1'b1;
  end

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_cmd_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int LO_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              fw_enable,
  input  logic              bg_entered,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_dbg_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_be,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ack,
  output logic              align_err,
  output logic              bg_req
);

  exec_st_e         st;
  cmd_dec_t         dec;
  logic             take;
  logic [LANES-1:0] be_new;
  logic             misal;
  logic             hs_en;
  logic             pend_byte;
  logic [LO_W-1:0]  pend_lo;
  logic [DATA_W-1:0] steered;

  assign take = cmd_valid && (st == ST_IDLE);
  assign busy = (st != ST_IDLE);

  dbg_cmd_decode #(.OP_W(OP_W)) u_dec (
    .op  (cmd_op),
    .dec (dec)
  );

  dbg_be_gen #(.DATA_W(DATA_W)) u_be (
    .addr_lo    (cmd_addr[LO_W-1:0]),
    .is_byte    (dec.is_byte),
    .be         (be_new),
    .misaligned (misal)
  );

  dbg_rd_steer #(.DATA_W(DATA_W)) u_steer (
    .addr_lo (pend_lo),
    .is_byte (pend_byte),
    .din     (bus_rdata),
    .dout    (steered)
  );

  dbg_hs_flag u_hs (
    .clk    (clk),
    .rst    (rst),
    .set_en (take && dec.kind == K_HS_ON),
    .clr_en (take && dec.kind == K_HS_OFF),
    .hs_en  (hs_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bus_req     <= 1'b0;
      bus_we      <= 1'b0;
      bus_dbg_sel <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_be      <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      ack         <= 1'b0;
      align_err   <= 1'b0;
      bg_req      <= 1'b0;
      pend_byte   <= 1'b0;
      pend_lo     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ack       <= 1'b0;
      align_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take) begin
            case (dec.kind)
              K_READ, K_WRITE: begin
                if (misal) begin
                  align_err <= 1'b1;
                end else begin
                  bus_req     <= 1'b1;
                  bus_we      <= (dec.kind == K_WRITE);
                  bus_dbg_sel <= dec.dbg_map;
                  bus_addr    <= cmd_addr;
                  bus_wdata   <= cmd_wdata;
                  bus_be      <= be_new;
                  pend_byte   <= dec.is_byte;
                  pend_lo     <= cmd_addr[LO_W-1:0];
                  st          <= ST_BUS;
                end
              end
              K_BGND: begin
                if (fw_enable) begin
                  bg_req <= 1'b1;
                  st     <= ST_BG;
                end
              end
              K_HS_ON:  ack <= 1'b1;
              default:  ;
            endcase
          end
        end
        ST_BUS: begin
          if (bus_gnt) begin
            bus_req     <= 1'b0;
            bus_dbg_sel <= 1'b0;
            bus_we      <= 1'b0;
            rsp_valid   <= !bus_we;
            if (!bus_we) rsp_data <= steered;
            ack         <= hs_en;
            st          <= ST_IDLE;
          end
        end
        ST_BG: begin
          if (bg_entered) begin
            bg_req <= 1'b0;
            ack    <= hs_en;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R5
  ack_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(hs_en) || hs_en);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |-> !ack && !rsp_valid && !bus_req);

  // R7
  bg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bg_req && !bg_entered |=> bg_req);

  // R9
  rsp_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_req) && $past(bus_gnt));

  // R1
  sel_only_bus_chk: assert property (@(posedge clk) disable iff (rst)
    bus_dbg_sel |-> bus_req);

endmodule

// File: tb/sim_dbg_cmd_exec.sv
module sim_dbg_cmd_exec;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [7:0]  cmd_op;
  logic [15:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic        fw_enable;
  logic        bg_entered;
  logic        busy, bus_req, bus_we, bus_dbg_sel;
  logic [15:0] bus_addr, bus_wdata;
  logic [1:0]  bus_be;
  logic        bus_gnt;
  logic [15:0] bus_rdata;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ack, align_err, bg_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dbg_cmd_exec u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .fw_enable(fw_enable),
    .bg_entered(bg_entered), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
    .bus_dbg_sel(bus_dbg_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ack(ack),
    .align_err(align_err), .bg_req(bg_req)
  );

  // bus model: application memory plus a debug window at 0xFF00..0xFF07
  logic [15:0] mem [256];
  logic [15:0] dregs [4];
  int gnt_delay = 0;
  int wait_cnt = 0;
  int bus_cnt = 0;
  logic last_sel, last_we;
  logic [1:0] last_be;
  logic [15:0] last_wdata;
  logic in_win;

  assign in_win    = bus_dbg_sel && (bus_addr[15:8] == 8'hFF);
  assign bus_gnt   = bus_req && (wait_cnt >= gnt_delay);
  assign bus_rdata = in_win ? dregs[bus_addr[2:1]] : mem[bus_addr[8:1]];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
    for (int j = 0; j < 4; j++) dregs[j] = {8'hD0 + 8'(j), 8'hB0 + 8'(j)};
  end

  always @(posedge clk) begin
    if (bus_req && !bus_gnt) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (bus_req && bus_gnt) begin
      bus_cnt    <= bus_cnt + 1;
      last_sel   <= bus_dbg_sel;
      last_we    <= bus_we;
      last_be    <= bus_be;
      last_wdata <= bus_wdata;
      if (bus_we) begin
        if (in_win) begin
          if (bus_be[1]) dregs[bus_addr[2:1]][15:8] <= bus_wdata[15:8];
          if (bus_be[0]) dregs[bus_addr[2:1]][7:0]  <= bus_wdata[7:0];
        end else begin
          if (bus_be[1]) mem[bus_addr[8:1]][15:8] <= bus_wdata[15:8];
          if (bus_be[0]) mem[bus_addr[8:1]][7:0]  <= bus_wdata[7:0];
        end
      end
    end
  end

  // background entry completes three cycles after the request is seen
  int bg_cnt = 0;
  always @(posedge clk) begin
    if (bg_req && bg_cnt < 3) bg_cnt <= bg_cnt + 1;
    else if (!bg_req) bg_cnt <= 0;
  end
  assign bg_entered = bg_req && (bg_cnt >= 3);

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // observed outcome of one command
  int n_ack, n_rsp, n_err, n_bus, n_bgreq, ack_before_bg;
  logic [15:0] got_data;

  task automatic run_cmd(input logic [7:0] op, input logic [15:0] addr,
                         input logic [15:0] wd);
    int b0;
    n_ack = 0; n_rsp = 0; n_err = 0; n_bgreq = 0; ack_before_bg = 0;
    got_data = 16'h0;
    b0 = bus_cnt;
    @(negedge clk);
    cmd_op = op; cmd_addr = addr; cmd_wdata = wd; cmd_valid = 1'b1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (c == 0) cmd_valid = 1'b0;
      if (ack) begin
        n_ack++;
        if (bg_req) ack_before_bg++;
      end
      if (rsp_valid) begin n_rsp++; got_data = rsp_data; end
      if (align_err) n_err++;
      if (bg_req) n_bgreq++;
    end
    n_bus = bus_cnt - b0;
  endtask

  // op, addr, wdata, expected data, check data, ack, err, bus count, sel
  localparam int NV = 15;
  localparam logic [60:0] VEC [NV] = '{
    {8'hD5, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hE8, 16'h0010, 16'h0000, 16'h5208, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hE0, 16'h0010, 16'h0000, 16'h5200, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hE0, 16'h0011, 16'h0000, 16'h0008, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hC4, 16'h0021, 16'h00EE, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hE8, 16'h0020, 16'h0000, 16'h4AEE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hEC, 16'hFF02, 16'h0000, 16'hD1B1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hE8, 16'hFF02, 16'h0000, 16'hDB81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hE4, 16'hFF03, 16'h0000, 16'h00B1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hE8, 16'h0013, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h77, 16'h0010, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hD6, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hE8, 16'h0010, 16'h0000, 16'h5208, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hC4, 16'hFF04, 16'h5500, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'hEC, 16'hFF04, 16'h0000, 16'h55B2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
    fw_enable = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({bus_req, rsp_valid, ack, align_err, bg_req, busy} == 6'b0, "R10 reset outputs",
        {10'h0, bus_req, rsp_valid, ack, align_err, bg_req, busy}, 16'h0);
    rst = 1'b0;

    // table: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [60:0] e;
      e = VEC[v];
      run_cmd(e[60:53], e[52:37], e[36:21]);
      chk(n_ack == int'(e[3]), "R5/R6 ack count", 16'(n_ack), 16'(e[3]));
      chk(n_err == int'(e[2]), "R4 align_err", 16'(n_err), 16'(e[2]));
      chk(n_bus == int'(e[1]), "R1/R8 bus accesses", 16'(n_bus), 16'(e[1]));
      if (e[1]) chk(last_sel == e[0], "R1/R3 dbg select", 16'(last_sel), 16'(e[0]));
      if (e[4]) begin
        chk(n_rsp == 1 && got_data == e[20:5], "R1/R2 read data", got_data, e[20:5]);
      end else begin
        chk(n_rsp == 0, "R3/R4/R8 no response", 16'(n_rsp), 16'h0);
      end
      if (e[60:53] == 8'hC4) begin
        chk(last_we && last_be == (e[37] ? 2'b01 : 2'b10) && last_wdata == e[36:21],
            "R3 write lane", {last_we, 7'h0, 6'h0, last_be}, {1'b1, 13'h0, e[37] ? 2'b01 : 2'b10});
      end
    end

    // R4 mapped word command unaligned
    run_cmd(8'hEC, 16'hFF01, 16'h0);
    chk(n_err == 1 && n_bus == 0 && n_rsp == 0, "R4 mapped unaligned", 16'(n_bus), 16'h0);

    // R7 background with firmware disabled
    run_cmd(8'hD5, 16'h0, 16'h0);
    fw_enable = 1'b0;
    run_cmd(8'h90, 16'h0, 16'h0);
    chk(n_bgreq == 0 && n_ack == 0, "R7 bg gated off", 16'(n_bgreq + n_ack), 16'h0);
    // R7 background with firmware enabled: ack only once entered
    fw_enable = 1'b1;
    run_cmd(8'h90, 16'h0, 16'h0);
    chk(n_bgreq >= 3, "R7 bg_req held", 16'(n_bgreq), 16'd3);
    chk(n_ack == 1 && ack_before_bg == 0, "R7 ack after entry", 16'(n_ack), 16'h1);
    fw_enable = 1'b0;

    // R9 grant delay: data unchanged, bus held
    gnt_delay = 4;
    run_cmd(8'hE0, 16'h0011, 16'h0);
    chk(n_rsp == 1 && got_data == 16'h0008 && n_ack == 1, "R9 delayed grant data", got_data, 16'h0008);

    // R9 command offered while busy is ignored (a D6 would clear the handshake)
    @(negedge clk);
    cmd_op = 8'hE8; cmd_addr = 16'h0010; cmd_valid = 1'b1;
    @(negedge clk);
    chk(busy, "R9 busy after accept", 16'(busy), 16'h1);
    cmd_op = 8'hD6;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    gnt_delay = 0;
    run_cmd(8'hE8, 16'h0010, 16'h0);
    chk(n_ack == 1, "R9 busy command ignored", 16'(n_ack), 16'h1);

    // R5 reset clears the handshake flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    run_cmd(8'hE8, 16'h0010, 16'h0);
    chk(n_ack == 0 && got_data == 16'h5208, "R5 reset clears handshake", 16'(n_ack), 16'h0);

    // R8 another unknown opcode
    run_cmd(8'h00, 16'h0010, 16'h0);
    chk(n_bus == 0 && n_rsp == 0 && n_err == 0, "R8 opcode 00 ignored", 16'(n_bus), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule